// File: doc/BRIEF.md
# Packed Float-to-Integer Lane Converter

This block turns floating-point values held in a 64-bit source word into signed integers and writes them into a copy of a 64-bit destination word. A source lane is either a 32-bit single-precision value or a 64-bit double-precision value. A result lane is either a 32-bit or a 64-bit two's-complement integer. A 64-bit word therefore carries at most two lanes. The lane count, the lane that is read and the lane that is written all follow from the two element sizes and a 3-bit control field.

The control field does three jobs. Bit 0 asks for scalar operation. Bit 1 steers the lane into the upper half of the word when the element sizes differ. Bit 2 picks rounding to the nearest integer, with halves moved away from zero, in place of truncation toward zero. Destination bits that no lane writes keep their old value. Each conversion is accepted together with a valid strobe, and the merged word comes out one clock later.

Top module: `pk_f2i_lanes`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` is 0 and `out_word` is all zeros.
- R2: `out_valid` equals `in_valid` of the previous cycle, and `out_word` shows the result of the operands given in that cycle. No result appears without an input.
- R3: With `src_dbl`=0 and `dst_dbl`=0 (0 means 32-bit, 1 means 64-bit) and `ctrl[0]`=0, two lanes are converted. Source bits [31:0] go to result bits [31:0], and source bits [63:32] go to result bits [63:32].
- R4: With both sizes 32-bit and `ctrl[0]`=1, only source bits [31:0] are converted into result bits [31:0]. Result bits [63:32] equal `dst_word[63:32]`.
- R5: With a 64-bit double source and a 32-bit result, one lane is converted. It is written to bits [63:32] when `ctrl[1]`=1 and to bits [31:0] otherwise, and the other half keeps `dst_word`.
- R6: With a 32-bit single source and a 64-bit result, source bits [63:32] are read when `ctrl[1]`=1 and bits [31:0] otherwise. All 64 result bits are written.
- R7: With `ctrl[2]`=0 the value is truncated toward zero (2.5 gives 2, -2.5 gives -2).
- R8: With `ctrl[2]`=1 the value is rounded to the nearest integer, with exact halves moved away from zero (2.5 gives 3, -2.5 gives -3, 0.5 gives 1, and just under 0.5 gives 0).
- R9: Zeros, subnormals and magnitudes that stay below 1 after rounding give 0.
- R10: NaN, infinity, and any value whose integer magnitude is 2^(W-1) or more give the most negative value of the result width W: 0x80000000 for 32-bit results and 0x8000000000000000 for 64-bit results.
- R11: Negative in-range results are two's complement at the result width. A 32-bit result does not spread into the neighbouring half of the word.
- R12: With both sizes 64-bit, the whole word is replaced by the 64-bit integer of the double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| src_word | input | 64 | Packed floating-point source word |
| dst_word | input | 64 | Previous destination word, merged around written lanes |
| src_dbl | input | 1 | Source element size: 0 = 32-bit single, 1 = 64-bit double |
| dst_dbl | input | 1 | Result element size: 0 = 32-bit, 1 = 64-bit |
| ctrl | input | 3 | Bit 0 scalar, bit 1 upper-half steering, bit 2 round half away from zero |
| out_valid | output | 1 | Result valid |
| out_word | output | 64 | Merged destination word |

## Verification
The bench targets the values sitting right on the rounding edges: exact halves of either sign, the largest double below one half, and a fraction just under one. A design that adds 0.5 with a rounding floating add would turn the value just below one half into 1, and a design that rounds the wrong way on negatives would give -2 instead of -3. The bench also targets the range edges. At 2^31 a 32-bit result must give the indefinite pattern while a 64-bit result gives the plain value, and 2^63 minus one unit must still convert. An off-by-one range test shows up as either a wrapped positive number or a missing indefinite. Finally, the bench sweeps every size pairing against all eight control codes. This catches a wrong steering offset, which lands a result in the wrong half or clobbers bits that must be preserved, and sign handling that leaks a 32-bit negative result into the neighbouring lane.

// File: rtl/pk_f2i_pkg.sv
package pk_f2i_pkg;

    localparam int WORD_W     = 64;
    localparam int NARROW_W   = 32;
    localparam int LANES      = WORD_W / NARROW_W;
    localparam int OFS_W      = $clog2(WORD_W) + 1;

    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int SP_BIAS    = 127;
    localparam int DP_EXP_W   = 11;
    localparam int DP_FRAC_W  = 52;
    localparam int DP_BIAS    = 1023;

    localparam int SIG_W      = DP_FRAC_W + 1;
    localparam int EXP_W      = DP_EXP_W + 2;
    localparam int PAD_W      = SIG_W - 1 - SP_FRAC_W;

    typedef enum logic [1:0] {
        FK_TINY    = 2'd0,
        FK_NORMAL  = 2'd1,
        FK_SPECIAL = 2'd2
    } fp_kind_e;

    typedef struct packed {
        logic                    sign;
        fp_kind_e                kind;
        logic signed [EXP_W-1:0] exp;
        logic [SIG_W-1:0]        sig;
    } fp_fields_t;

    typedef struct packed {
        logic round_half;
        logic upper_half;
        logic scalar;
    } cvt_ctrl_t;

    typedef struct packed {
        logic [LANES-1:0] lane_en;
        logic [OFS_W-1:0] src_base;
        logic [OFS_W-1:0] dst_base;
    } lane_plan_t;

    function automatic lane_plan_t plan_lanes(input logic src_wide,
                                              input logic dst_wide,
                                              input cvt_ctrl_t c);
        lane_plan_t p;
        p.lane_en    = '0;
        p.lane_en[0] = 1'b1;
        p.src_base   = '0;
        p.dst_base   = '0;
        if (!src_wide && !dst_wide) begin
            if (!c.scalar) p.lane_en = '1;
        end else if (src_wide && !dst_wide) begin
            if (c.upper_half) p.dst_base = OFS_W'(NARROW_W);
        end else if (!src_wide && dst_wide) begin
            if (c.upper_half) p.src_base = OFS_W'(NARROW_W);
        end
        return p;
    endfunction

    function automatic logic [OFS_W-1:0] lane_offset(input logic [OFS_W-1:0] base,
                                                     input int lane,
                                                     input logic wide);
        logic [OFS_W-1:0] step;
        step = wide ? OFS_W'(WORD_W) : OFS_W'(NARROW_W);
        return base + OFS_W'(lane) * step;
    endfunction

    function automatic logic [WORD_W-1:0] field_mask(input logic wide);
        return wide ? {WORD_W{1'b1}} : {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

endpackage

// File: rtl/pk_f2i_unpack.sv
module pk_f2i_unpack
    import pk_f2i_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic              is_double,
    output fp_fields_t        fields
);
    logic [SP_EXP_W-1:0] sp_exp;
    logic [DP_EXP_W-1:0] dp_exp;

    always_comb begin
        sp_exp = raw[SP_FRAC_W +: SP_EXP_W];
        dp_exp = raw[DP_FRAC_W +: DP_EXP_W];
        if (is_double) begin
            fields.sign = raw[WORD_W-1];
            fields.exp  = $signed({2'b00, dp_exp}) - EXP_W'(DP_BIAS);
            fields.sig  = {1'b1, raw[DP_FRAC_W-1:0]};
            if (dp_exp == '0)
                fields.kind = FK_TINY;
            else if (dp_exp == '1)
                fields.kind = FK_SPECIAL;
            else
                fields.kind = FK_NORMAL;
        end else begin
            fields.sign = raw[NARROW_W-1];
            fields.exp  = $signed({{(EXP_W-SP_EXP_W){1'b0}}, sp_exp}) - EXP_W'(SP_BIAS);
            fields.sig  = {1'b1, raw[SP_FRAC_W-1:0], {PAD_W{1'b0}}};
            if (sp_exp == '0)
                fields.kind = FK_TINY;
            else if (sp_exp == '1)
                fields.kind = FK_SPECIAL;
            else
                fields.kind = FK_NORMAL;
        end
    end
endmodule

// File: rtl/pk_f2i_to_int.sv
module pk_f2i_to_int
    import pk_f2i_pkg::*;
(
    input  fp_fields_t        fields,
    input  logic              dst_wide,
    input  logic              round_half,
    output logic [WORD_W-1:0] value
);
    localparam int Z_W      = SIG_W + WORD_W;
    localparam int HALF_TOP = Z_W - 2;
    localparam int MAX_EXP  = WORD_W - 2;
    localparam int SH_W     = $clog2(Z_W) + 1;
    localparam int MAG_W    = WORD_W + 1;

    logic [Z_W-1:0]    scaled;
    logic [MAG_W-1:0]  halves;
    logic [MAG_W-1:0]  mag;
    logic [SH_W-1:0]   sh;
    logic              too_big;
    logic              out_of_range;
    logic [WORD_W-1:0] signed_val;
    logic [WORD_W-1:0] indefinite;

    always_comb begin
        scaled  = {fields.sig, {WORD_W{1'b0}}};
        sh      = '0;
        halves  = '0;
        too_big = 1'b0;
        if (fields.kind == FK_SPECIAL) begin
            too_big = 1'b1;
        end else if (fields.kind == FK_NORMAL) begin
            if (fields.exp > EXP_W'(MAX_EXP)) begin
                too_big = 1'b1;
            end else if (fields.exp >= -EXP_W'(1)) begin
                sh     = SH_W'(EXP_W'(HALF_TOP) - fields.exp);
                halves = MAG_W'(scaled >> sh);
            end
        end

        mag = round_half ? ((halves + MAG_W'(1)) >> 1) : (halves >> 1);

        out_of_range = dst_wide ? (|mag[MAG_W-1:WORD_W-1])
                                : (|mag[MAG_W-1:NARROW_W-1]);

        signed_val = fields.sign ? (~mag[WORD_W-1:0] + WORD_W'(1)) : mag[WORD_W-1:0];

        indefinite = dst_wide ? {1'b1, {(WORD_W-1){1'b0}}}
                              : {{(WORD_W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

        if (too_big || out_of_range)
            value = indefinite;
        else
            value = signed_val & field_mask(dst_wide);
    end
endmodule

// File: rtl/pk_f2i_lanes.sv
module pk_f2i_lanes
    import pk_f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [63:0]       src_word,
    input  logic [63:0]       dst_word,
    input  logic              src_dbl,
    input  logic              dst_dbl,
    input  logic [2:0]        ctrl,
    output logic              out_valid,
    output logic [63:0]       out_word
);
    cvt_ctrl_t         c;
    lane_plan_t        plan;
    logic [WORD_W-1:0] lane_val  [LANES];
    logic [OFS_W-1:0]  lane_dofs [LANES];
    logic [WORD_W-1:0] merged;

    assign c    = cvt_ctrl_t'(ctrl);
    assign plan = plan_lanes(src_dbl, dst_dbl, c);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [OFS_W-1:0]  sofs;
        logic [WORD_W-1:0] raw;
        fp_fields_t        fields;

        assign sofs         = lane_offset(plan.src_base, g, src_dbl);
        assign raw          = src_word >> sofs;
        assign lane_dofs[g] = lane_offset(plan.dst_base, g, dst_dbl);

        pk_f2i_unpack u_unpack (
            .raw       (raw),
            .is_double (src_dbl),
            .fields    (fields)
        );

        pk_f2i_to_int u_to_int (
            .fields     (fields),
            .dst_wide   (dst_dbl),
            .round_half (c.round_half),
            .value      (lane_val[g])
        );
    end

    always_comb begin
        merged = dst_word;
        for (int i = 0; i < LANES; i++) begin
            if (plan.lane_en[i]) begin
                merged = (merged & ~(field_mask(dst_dbl) << lane_dofs[i]))
                       | ((lane_val[i] & field_mask(dst_dbl)) << lane_dofs[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= merged;
        end
    end
endmodule

// File: rtl/pk_f2i_lanes_chk.sv
module pk_f2i_lanes_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] src_word,
    input logic [63:0] dst_word,
    input logic        src_dbl,
    input logic        dst_dbl,
    input logic [2:0]  ctrl,
    input logic        out_valid,
    input logic [63:0] out_word
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == 64'd0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r4_scalar_keeps_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !src_dbl && !dst_dbl && ctrl[0])
        |=> out_word[63:32] == $past(dst_word[63:32]));

    a_r5_narrow_keeps_other: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_dbl && !dst_dbl)
        |=> ($past(ctrl[1]) ? (out_word[31:0]  == $past(dst_word[31:0]))
                            : (out_word[63:32] == $past(dst_word[63:32]))));

    a_r9_zero_gives_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_dbl && dst_dbl && src_word[62:0] == 63'd0)
        |=> out_word == 64'd0);

    a_r10_nan_indefinite: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_dbl && dst_dbl && src_word[62:52] == 11'h7FF)
        |=> out_word == 64'h8000_0000_0000_0000);
endmodule

bind pk_f2i_lanes pk_f2i_lanes_chk u_pk_f2i_lanes_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_word  (src_word),
    .dst_word  (dst_word),
    .src_dbl   (src_dbl),
    .dst_dbl   (dst_dbl),
    .ctrl      (ctrl),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/test_pk_f2i_lanes.sv
`timescale 1ns/1ps
module test_pk_f2i_lanes;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src_word = '0;
    logic [63:0] dst_word = '0;
    logic        src_dbl = 1'b0;
    logic        dst_dbl = 1'b0;
    logic [2:0]  ctrl = '0;
    logic        out_valid;
    logic [63:0] out_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pk_f2i_lanes i_pk_f2i_lanes (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_word(src_word),
        .dst_word(dst_word), .src_dbl(src_dbl), .dst_dbl(dst_dbl), .ctrl(ctrl),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [63:0] ref_lane(input logic [63:0] raw, input bit s_dbl,
                                             input bit d_dbl, input bit rnd);
        logic [63:0] db;
        logic [63:0] indef;
        bit          special;
        bit          neg;
        real         a;
        real         f;
        real         lim;
        longint      v;
        indef = d_dbl ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
        if (s_dbl) begin
            db      = raw;
            special = (raw[62:52] == 11'h7FF);
        end else begin
            special = (raw[30:23] == 8'hFF);
            if (raw[30:23] == 8'h00) db = {raw[31], 63'd0};
            else db = {raw[31], 11'(raw[30:23]) + 11'd896, raw[22:0], 29'd0};
        end
        if (special) return indef;
        neg = db[63];
        a = $bitstoreal({1'b0, db[62:0]});
        f = $floor(a);
        if (rnd && (a - f) >= 0.5) f = f + 1.0;
        lim = d_dbl ? 9223372036854775808.0 : 2147483648.0;
        if (f >= lim) return indef;
        v = longint'(f);
        if (neg) v = -v;
        return d_dbl ? 64'(v) : {32'd0, v[31:0]};
    endfunction

    function automatic logic [63:0] ref_word(input logic [63:0] s, input logic [63:0] d,
                                             input bit sd, input bit dd, input logic [2:0] c);
        logic [63:0] e;
        logic [63:0] r;
        e = d;
        case ({sd, dd})
            2'b00: begin
                r = ref_lane({32'd0, s[31:0]}, 0, 0, c[2]);
                e[31:0] = r[31:0];
                if (!c[0]) begin
                    r = ref_lane({32'd0, s[63:32]}, 0, 0, c[2]);
                    e[63:32] = r[31:0];
                end
            end
            2'b11: e = ref_lane(s, 1, 1, c[2]);
            2'b10: begin
                r = ref_lane(s, 1, 0, c[2]);
                if (c[1]) e[63:32] = r[31:0];
                else e[31:0] = r[31:0];
            end
            default: e = ref_lane({32'd0, c[1] ? s[63:32] : s[31:0]}, 0, 1, c[2]);
        endcase
        return e;
    endfunction

    task automatic drive(input logic [63:0] s, input logic [63:0] d, input bit sd,
                         input bit dd, input logic [2:0] c, input string tag);
        @(negedge clk);
        exp_q.push_back(ref_word(s, d, sd, dd, c));
        tag_q.push_back(tag);
        src_word = s; dst_word = d; src_dbl = sd; dst_dbl = dd; ctrl = c;
        in_valid = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: result with no pending input, actual %h expected none", out_word);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_word !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, out_word, e);
                end
            end
        end
    end

    function automatic logic [31:0] rnd_single();
        logic [7:0] ex;
        ex = 8'(100 + ($urandom % 66));
        return {1'($urandom), ex, 23'($urandom)};
    endfunction

    function automatic logic [63:0] rnd_double();
        logic [10:0] ex;
        ex = 11'(1010 + ($urandom % 84));
        return {1'($urandom), ex, 20'($urandom), 32'($urandom)};
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_word !== 64'd0) begin
            errors++;
            $display("FAIL R1: actual valid=%b word=%h expected 0/0", out_valid, out_word);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_word !== 64'd0) begin
            errors++;
            $display("FAIL R1: after release actual valid=%b word=%h expected 0/0", out_valid, out_word);
        end

        // R7 / R8 / R11 / R12: 2.5 and -2.5, truncate and round
        drive(64'h4004_0000_0000_0000, 64'hDEAD_BEEF_0000_1111, 1, 1, 3'b000, "R7");
        drive(64'h4004_0000_0000_0000, 64'h0, 1, 1, 3'b100, "R8");
        drive(64'hC004_0000_0000_0000, 64'h0, 1, 1, 3'b000, "R11");
        drive(64'hC004_0000_0000_0000, 64'h0, 1, 1, 3'b100, "R8");
        // R8: exactly one half, and just under one half
        drive(64'h3FE0_0000_0000_0000, 64'h5, 1, 1, 3'b100, "R8");
        drive(64'h3FDF_FFFF_FFFF_FFFF, 64'h5, 1, 1, 3'b100, "R8");
        drive(64'h3FEF_FFFF_FFFF_FFFF, 64'h5, 1, 1, 3'b000, "R9");
        // R10: NaN, infinity, range limits
        drive(64'h7FF8_0000_0000_0000, 64'h1, 1, 1, 3'b000, "R10");
        drive(64'hFFF0_0000_0000_0000, 64'h1, 1, 1, 3'b100, "R10");
        drive(64'h43E0_0000_0000_0000, 64'h1, 1, 1, 3'b000, "R10");
        drive(64'h43DF_FFFF_FFFF_FFFF, 64'h1, 1, 1, 3'b100, "R12");
        drive({32'h0, 32'h4F00_0000}, 64'h0, 0, 0, 3'b001, "R10");
        drive({32'h0, 32'h4F00_0000}, 64'h0, 0, 1, 3'b000, "R6");
        // R9: subnormal and zero
        drive({32'h8000_0001, 32'h0000_0001}, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 3'b100, "R9");
        drive(64'h0, 64'h1234, 1, 1, 3'b100, "R9");
        // R3 packed, R4 scalar
        drive({32'hBFC0_0000, 32'h406C_CCCD}, 64'h1111_2222_3333_4444, 0, 0, 3'b000, "R3");
        drive({32'hBFC0_0000, 32'h406C_CCCD}, 64'h1111_2222_3333_4444, 0, 0, 3'b100, "R3");
        drive({32'hBFC0_0000, 32'h406C_CCCD}, 64'h1111_2222_3333_4444, 0, 0, 3'b001, "R4");
        // R5 narrowing steering
        drive(64'h4059_0000_0000_0000, 64'hAAAA_AAAA_5555_5555, 1, 0, 3'b010, "R5");
        drive(64'hC059_0000_0000_0000, 64'hAAAA_AAAA_5555_5555, 1, 0, 3'b000, "R5");
        // R6 widening steering
        drive({32'hC0E0_0000, 32'h3F80_0000}, 64'hFFFF_0000_FFFF_0000, 0, 1, 3'b010, "R6");
        drive({32'hC0E0_0000, 32'h3F80_0000}, 64'hFFFF_0000_FFFF_0000, 0, 1, 3'b000, "R6");
        idle();
        idle();
        // R2: idle output stays low
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: idle actual valid=%b expected 0", out_valid);
        end

        // Sweep all size pairs and control codes (R3 R4 R5 R6 R7 R8 R12)
        for (int sz = 0; sz < 4; sz++) begin
            for (int cc = 0; cc < 8; cc++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [63:0] s;
                    bit sd;
                    bit dd;
                    sd = sz[1];
                    dd = sz[0];
                    s = sd ? rnd_double() : {rnd_single(), rnd_single()};
                    drive(s, {$urandom, $urandom}, sd, dd, 3'(cc), "R3_R4_R5_R6_sweep");
                end
            end
        end
        idle();
        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: actual %0d results missing expected 0", exp_q.size());
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule